// File: doc/BRIEF.md
# Fixed-Priority Stream Merger

This block folds several independent valid/ready streams into a single output stream without any storage. Each cycle it looks at all input lanes. If only one is valid, that beat goes through. If several are valid, the lane with the smallest index is taken and every other valid beat in that cycle is discarded. The chosen beat appears on a registered output one clock later.

The output word is wider than an input word. The input data is zero-extended into the low bits of the output word. When destination packing is enabled, which is the default, the low byte of the chosen beat's routing field also goes into the top byte of the output word. A downstream consumer can then route on the data word alone. The routing field is always driven on its own output as well.

Back-pressure rules: the block never holds an input back, so every input ready is held high at all times. The output has no ready. The consumer must accept one beat in any cycle where the output valid is high. Beats that lose a collision are gone and are not recorded anywhere.

Top module: `prio_stream_merge`

## Requirements
- R1: While rst_n is low at a rising clock edge (synchronous, active-low reset), out_valid is 0 after that edge.
- R2: Every bit of in_ready is 1 in every cycle, including during reset.
- R3: If at least one lane is valid at a rising edge out of reset, out_valid is 1 after that edge. out_data[IN_W-1:0] then equals the chosen lane's data, one cycle of latency.
- R4: When several lanes are valid in the same cycle, the chosen lane is the one with the lowest index.
- R5: If no lane is valid at a rising edge out of reset, out_valid is 0 after that edge.
- R6: With PACK_DEST=1 (default), out_data[OUT_W-1:OUT_W-8] holds bits [7:0] of the chosen lane's in_dest. out_data[OUT_W-9:IN_W] is zero.
- R7: out_dest equals the full in_dest of the chosen lane whenever out_valid is 1.
- R8: Losing beats are dropped. A collision cycle followed by an idle cycle gives exactly one output beat and then out_valid 0.
- R9: With PACK_DEST=0, out_data[OUT_W-1:IN_W] is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | N_IN | Per-lane beat valid, lane i is bit i |
| in_data | input | N_IN*IN_W | Lane i data at bits [i*IN_W +: IN_W] |
| in_dest | input | N_IN*DEST_W | Lane i routing field at bits [i*DEST_W +: DEST_W] |
| in_ready | output | N_IN | Per-lane ready, always high |
| out_valid | output | 1 | Registered output beat valid |
| out_data | output | OUT_W | Widened output word |
| out_dest | output | DEST_W | Routing field of the chosen beat |

## Verification
The merger is driven with one lane valid at a time, which shows that each lane's data and routing field land in the right bit positions. It is also driven with dense collisions, where several or all lanes are valid at once, which separates a lowest-index winner from any other selection order. Idle gaps after collisions show that dropped beats never come out later. Pseudo-random valid masks mix all of these cases. A second instance with packing disabled separates the packed upper byte from a zero-filled one.

// File: rtl/psm_pkg.sv
package psm_pkg;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/psm_grant.sv
// Fixed-priority one-hot grant: the lowest set request bit wins.
module psm_grant #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] taken;
  assign taken[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]   = req[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req[i];
  end
  assign any = taken[N];
endmodule

// File: rtl/psm_select.sv
// One-hot AND-OR selector over N packed lanes of width W.
module psm_select #(
  parameter int unsigned N = 6,
  parameter int unsigned W = 16
) (
  input  logic [N-1:0]   onehot,
  input  logic [N*W-1:0] lanes,
  output logic [W-1:0]   picked
);
  logic [W-1:0] masked [N];
  for (genvar i = 0; i < N; i++) begin : g_mask
    assign masked[i] = lanes[i*W +: W] & {W{onehot[i]}};
  end
  always_comb begin
    picked = '0;
    for (int i = 0; i < N; i++) picked = picked | masked[i];
  end
endmodule

// File: rtl/psm_format.sv
// Builds the widened output word, optionally placing a routing byte on top.
module psm_format
  import psm_pkg::*;
#(
  parameter int unsigned IN_W   = 16,
  parameter int unsigned OUT_W  = 32,
  parameter bit          PACK   = 1'b1
) (
  input  logic [IN_W-1:0]   data,
  input  logic [BYTE_W-1:0] dest_byte,
  output logic [OUT_W-1:0]  word
);
  if (PACK) begin : g_pack
    always_comb begin
      word = '0;
      word[IN_W-1:0] = data;
      word[OUT_W-1 -: BYTE_W] = dest_byte;
    end
  end else begin : g_plain
    logic [BYTE_W-1:0] unused_byte;
    assign unused_byte = dest_byte;
    always_comb begin
      word = '0;
      word[IN_W-1:0] = data;
    end
  end
endmodule

// File: rtl/prio_stream_merge.sv
module prio_stream_merge
  import psm_pkg::*;
#(
  parameter int unsigned N_IN      = 6,
  parameter int unsigned IN_W      = 16,
  parameter int unsigned OUT_W     = 32,
  parameter int unsigned DEST_W    = 8,
  parameter bit          PACK_DEST = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_IN-1:0]      in_valid,
  input  logic [N_IN*IN_W-1:0] in_data,
  input  logic [N_IN*DEST_W-1:0] in_dest,
  output logic [N_IN-1:0]      in_ready,
  output logic                 out_valid,
  output logic [OUT_W-1:0]     out_data,
  output logic [DEST_W-1:0]    out_dest
);
  logic [N_IN-1:0]   grant;
  logic              any_valid;
  logic [IN_W-1:0]   win_data;
  logic [DEST_W-1:0] win_dest;
  logic [OUT_W-1:0]  word;

  assign in_ready = '1;

  psm_grant #(.N(N_IN)) u_grant (
    .req(in_valid), .grant(grant), .any(any_valid)
  );

  psm_select #(.N(N_IN), .W(IN_W)) u_sel_data (
    .onehot(grant), .lanes(in_data), .picked(win_data)
  );

  psm_select #(.N(N_IN), .W(DEST_W)) u_sel_dest (
    .onehot(grant), .lanes(in_dest), .picked(win_dest)
  );

  psm_format #(.IN_W(IN_W), .OUT_W(OUT_W), .PACK(PACK_DEST)) u_fmt (
    .data(win_data), .dest_byte(win_dest[BYTE_W-1:0]), .word(word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_dest  <= '0;
    end else begin
      out_valid <= any_valid;
      if (any_valid) begin
        out_data <= word;
        out_dest <= win_dest;
      end
    end
  end
endmodule

// File: rtl/prio_stream_merge_chk.sv
module prio_stream_merge_chk #(
  parameter int unsigned N_IN      = 6,
  parameter int unsigned IN_W      = 16,
  parameter int unsigned OUT_W     = 32,
  parameter int unsigned DEST_W    = 8,
  parameter bit          PACK_DEST = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_IN-1:0]   in_valid,
  input logic [IN_W-1:0]   lane0_data,
  input logic [DEST_W-1:0] lane0_dest,
  input logic [N_IN-1:0]   in_ready,
  input logic              out_valid,
  input logic [OUT_W-1:0]  out_data,
  input logic [DEST_W-1:0] out_dest
);
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !out_valid);

  a_r2_ready_high: assert property (@(posedge clk) in_ready == '1);

  a_r3_beat_out: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_valid) |=> out_valid);

  a_r5_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
    !(|in_valid) |=> !out_valid);

  a_r4_lane0_wins: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid[0] |=> (out_data[IN_W-1:0] == $past(lane0_data)));

  a_r7_lane0_dest: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid[0] |=> (out_dest == $past(lane0_dest)));

  if (PACK_DEST) begin : g_pack_chk
    a_r6_top_byte: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data[OUT_W-1 -: 8] == out_dest[7:0]));
  end else begin : g_plain_chk
    a_r9_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data[OUT_W-1:IN_W] == '0));
  end
endmodule

bind prio_stream_merge prio_stream_merge_chk #(
  .N_IN(N_IN), .IN_W(IN_W), .OUT_W(OUT_W), .DEST_W(DEST_W), .PACK_DEST(PACK_DEST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .lane0_data(in_data[IN_W-1:0]), .lane0_dest(in_dest[DEST_W-1:0]),
  .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
  .out_dest(out_dest)
);

// File: tb/tb_prio_stream_merge.sv
`timescale 1ns/1ps
module tb_prio_stream_merge;
  localparam int N = 6;
  localparam int IW = 16;
  localparam int OW = 32;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] in_valid = '0;
  logic [N*IW-1:0] in_data = '0;
  logic [N*DW-1:0] in_dest = '0;
  logic [N-1:0] rdy_a, rdy_b;
  logic v_a, v_b;
  logic [OW-1:0] d_a, d_b;
  logic [DW-1:0] t_a, t_b;

  int vectors = 0;
  int errors = 0;

  logic exp_v;
  logic [OW-1:0] exp_pack, exp_plain;
  logic [DW-1:0] exp_dest;
  string exp_tag;

  always #2 clk = ~clk;

  prio_stream_merge dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_dest(in_dest), .in_ready(rdy_a), .out_valid(v_a), .out_data(d_a),
    .out_dest(t_a)
  );

  prio_stream_merge #(.PACK_DEST(1'b0)) dut_nopack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_dest(in_dest), .in_ready(rdy_b), .out_valid(v_b), .out_data(d_b),
    .out_dest(t_b)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(rdy_a == '1 && rdy_b == '1, "R2", "in_ready", {rdy_a, rdy_b}, '1);
    chk(v_a == exp_v, exp_tag, "out_valid", v_a, exp_v);
    chk(v_b == exp_v, exp_tag, "out_valid nopack", v_b, exp_v);
    if (exp_v) begin
      chk(d_a == exp_pack, exp_tag == "R4" ? "R4" : "R6", "packed data", d_a, exp_pack);
      chk(d_b == exp_plain, "R9", "plain data", d_b, exp_plain);
      chk(t_a == exp_dest && t_b == exp_dest, "R7", "out_dest", t_a, exp_dest);
    end
  endtask

  // Apply a new input set on the falling edge and predict the next output.
  task automatic step(input bit rst, input logic [N-1:0] v, input string force_tag);
    int win;
    @(negedge clk);
    compare();
    rst_n = rst;
    in_valid = v;
    for (int i = 0; i < N; i++) begin
      in_data[i*IW +: IW] = IW'($urandom);
      in_dest[i*DW +: DW] = DW'($urandom);
    end
    win = -1;
    for (int i = N - 1; i >= 0; i--) if (v[i]) win = i;
    exp_v = rst && (win >= 0);
    if (!rst) exp_tag = "R1";
    else if (win < 0) exp_tag = "R5";
    else if ($countones(v) > 1) exp_tag = "R4";
    else exp_tag = "R3";
    if (force_tag != "") exp_tag = force_tag;
    if (win >= 0) begin
      exp_plain = '0;
      exp_plain[IW-1:0] = in_data[win*IW +: IW];
      exp_dest = in_dest[win*DW +: DW];
      exp_pack = exp_plain;
      exp_pack[OW-1 -: 8] = exp_dest[7:0];
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    exp_v = 1'b0; exp_tag = "R1";
    exp_pack = '0; exp_plain = '0; exp_dest = '0;
    // R1: reset with traffic present
    step(1'b0, '1, "");
    step(1'b0, 6'b000100, "");
    step(1'b0, '0, "");
    // R3: each lane alone
    for (int i = 0; i < N; i++) step(1'b1, N'(1) << i, "");
    // R5: idle
    step(1'b1, '0, "");
    // R4: collisions, R8: dropped losers vanish after an idle cycle
    step(1'b1, '1, "");
    step(1'b1, '0, "R8");
    step(1'b1, 6'b101100, "");
    step(1'b1, '0, "R8");
    step(1'b1, 6'b110000, "");
    step(1'b1, 6'b100001, "");
    step(1'b1, '0, "R8");
    // mixed pseudo-random traffic
    for (int k = 0; k < 400; k++) step(1'b1, N'($urandom), "");
    // reset in mid-stream, then recovery
    step(1'b0, '1, "");
    step(1'b1, 6'b011000, "");
    step(1'b1, '0, "");
    @(negedge clk);
    compare();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule